// File: doc/BRIEF.md
# Line Ping-Pong Colour-Plane Reorderer

This block sits in a streaming pixel path. It accepts one 24-bit RGB pixel per clock, with a data-enable, a horizontal sync and a vertical sync. Each active line is written into one of two on-chip line banks. The write is not in arrival order. Every red sample of the line goes into a contiguous red plane at byte addresses 0 to N-1. Every green sample goes into a green plane at N to 2N-1. Every blue sample goes into a blue plane at 2N to 3N-1.

While the next line is being written into the other bank, the bank filled during the previous line is read out in plain ascending byte order. Three consecutive bytes are packed into one output pixel. A panel driven from the output therefore shows the red, green and blue sub-images side by side, each one third of the line wide. The output carries the content of input line n during input line n+1. The output timing is that of the current input line, delayed by one clock of read latency.

Each bank is built from three byte-wide sub-RAMs, each N entries deep. Byte address a lives in sub-RAM a mod 3, at entry a div 3. The three colour components of one input pixel always fall into three different sub-RAMs, and so do the three bytes of one output pixel. This lets one full pixel be written and one full pixel be read on every clock. The scheme requires that N is not a multiple of 3.

Top module: `plane_line_reorder`

## Requirements
- R1: While reset is held, and until the first input line after reset, de_out, hs_out and vs_out are 0 and the three output colour buses are 0.
- R2: For input pixel i (counted from 0 within a line), the block stores red at byte address i, green at N+i and blue at 2N+i of the write bank. During the next line, output pixel k carries byte 3k on r_out, byte 3k+1 on g_out and byte 3k+2 on b_out.
- R3: The write bank and the read bank swap at the falling edge of de_in at the end of every line. The R2 mapping therefore holds for lines read from either bank, on consecutive lines.
- R4: de_out stays 0 for the whole first line after reset. It also stays 0 for the whole first line after a vertical-sync pulse, because no line has been buffered yet.
- R5: hs_out and vs_out equal hs_in and vs_in delayed by one clock. de_out, when high, is high one clock after de_in was high.
- R6: Only the first N pixels of a line are stored or output. Extra pixels while de_in stays high leave the buffered line unchanged, and de_out is high for at most N consecutive clocks.
- R7: Whenever de_out is 0, r_out, g_out and b_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vs_in | input | 1 | Vertical sync, active high |
| hs_in | input | 1 | Horizontal sync, active high |
| de_in | input | 1 | Input data enable, high during active pixels |
| r_in | input | CW | Red component of the input pixel |
| g_in | input | CW | Green component of the input pixel |
| b_in | input | CW | Blue component of the input pixel |
| vs_out | output | 1 | Delayed vertical sync |
| hs_out | output | 1 | Delayed horizontal sync |
| de_out | output | 1 | Output data enable |
| r_out | output | CW | Output byte 3k |
| g_out | output | CW | Output byte 3k+1 |
| b_out | output | CW | Output byte 3k+2 |

## Verification
The bench compares every output pixel of each line against the reordered bytes of the line driven before it, over several consecutive lines, so both bank polarities are covered. A design that failed to swap banks would return the line being written, or a stale line. A design with a wrong plane start would shift the green or blue sub-image.

The bench also drives an over-long line and then checks that the following output is exactly N pixels of that line's first N inputs. A counter that failed to saturate would wrap around and overwrite the start of the planes.

After a vertical-sync pulse the bench requires a fully dark line. A design that kept its valid state across the frame boundary would replay the last line of the previous frame.

// File: rtl/plane_line_reorder_pkg.sv
package plane_line_reorder_pkg;
   localparam int NSUB = 3;
   typedef logic [1:0] sub_t;
endpackage

// File: rtl/plane_addr_gen.sv
module plane_addr_gen
   import plane_line_reorder_pkg::*;
#(
   parameter int N     = 1024,
   parameter int START = 0,
   parameter int IW    = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output sub_t          sub_o,
   output logic [IW-1:0] idx_o
);
   localparam sub_t          SUB0 = sub_t'(START % NSUB);
   localparam logic [IW-1:0] IDX0 = IW'(START / NSUB);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sub_o <= SUB0;
         idx_o <= IDX0;
      end else if (adv) begin
         if (sub_o == sub_t'(NSUB - 1)) begin
            sub_o <= '0;
            idx_o <= idx_o + 1'b1;
         end else begin
            sub_o <= sub_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/line_bank.sv
module line_bank
   import plane_line_reorder_pkg::*;
#(
   parameter int N  = 1024,
   parameter int CW = 8,
   parameter int IW = $clog2(N)
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [NSUB-1:0][IW-1:0]  wr_idx,
   input  logic [NSUB-1:0][CW-1:0]  wr_dat,
   input  logic [IW-1:0]            rd_idx,
   output logic [NSUB-1:0][CW-1:0]  rd_dat
);
   for (genvar s = 0; s < NSUB; s++) begin : g_sub
      logic [CW-1:0] mem [N];
      always_ff @(posedge clk) begin
         if (we) mem[wr_idx[s]] <= wr_dat[s];
         rd_dat[s] <= mem[rd_idx];
      end
   end
endmodule

// File: rtl/plane_line_reorder.sv
module plane_line_reorder
   import plane_line_reorder_pkg::*;
#(
   parameter int N  = 1024,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vs_in,
   input  logic          hs_in,
   input  logic          de_in,
   input  logic [CW-1:0] r_in,
   input  logic [CW-1:0] g_in,
   input  logic [CW-1:0] b_in,
   output logic          vs_out,
   output logic          hs_out,
   output logic          de_out,
   output logic [CW-1:0] r_out,
   output logic [CW-1:0] g_out,
   output logic [CW-1:0] b_out
);
   localparam int IW = $clog2(N);

   if (N % NSUB == 0) begin : g_bad_n
      $error("N must not be a multiple of 3");
   end
   if (CW < 1 || N < 4) begin : g_bad_w
      $error("CW and N out of range");
   end

   logic [IW:0] pcnt;
   logic        active, de_d, de_fall, wsel, valid, rsel_q, de_q;
   logic [NSUB-1:0][CW-1:0] comp, wd;
   logic [NSUB-1:0][IW-1:0] wi;
   sub_t    [NSUB-1:0]      tsub;
   logic    [NSUB-1:0][IW-1:0] tidx;
   logic [1:0][NSUB-1:0][CW-1:0] rd;

   assign active  = de_in && (pcnt < (IW+1)'(N));
   assign de_fall = de_d && !de_in;
   assign comp    = {b_in, g_in, r_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt   <= '0;
         de_d   <= 1'b0;
         wsel   <= 1'b0;
         valid  <= 1'b0;
         rsel_q <= 1'b0;
         de_q   <= 1'b0;
         hs_out <= 1'b0;
         vs_out <= 1'b0;
      end else begin
         de_d   <= de_in;
         pcnt   <= !de_in ? '0 : (active ? pcnt + 1'b1 : pcnt);
         if (de_fall) wsel <= !wsel;
         if (vs_in) valid <= 1'b0;
         else if (de_fall) valid <= 1'b1;
         rsel_q <= !wsel;
         de_q   <= active && valid;
         hs_out <= hs_in;
         vs_out <= vs_in;
      end
   end

   for (genvar c = 0; c < NSUB; c++) begin : g_trk
      plane_addr_gen #(.N(N), .START(c * N), .IW(IW)) u_trk (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!de_in),
         .adv   (active),
         .sub_o (tsub[c]),
         .idx_o (tidx[c])
      );
   end

   always_comb begin
      wd = '0;
      wi = '0;
      for (int s = 0; s < NSUB; s++) begin
         for (int c = 0; c < NSUB; c++) begin
            if (tsub[c] == sub_t'(s)) begin
               wd[s] = comp[c];
               wi[s] = tidx[c];
            end
         end
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      line_bank #(.N(N), .CW(CW), .IW(IW)) u_bank (
         .clk    (clk),
         .we     (active && (wsel == 1'(b))),
         .wr_idx (wi),
         .wr_dat (wd),
         .rd_idx (pcnt[IW-1:0]),
         .rd_dat (rd[b])
      );
   end

   assign de_out = de_q;
   assign r_out  = de_q ? rd[rsel_q][0] : '0;
   assign g_out  = de_q ? rd[rsel_q][1] : '0;
   assign b_out  = de_q ? rd[rsel_q][2] : '0;
endmodule

// File: rtl/plane_line_reorder_chk.sv
module plane_line_reorder_chk #(
   parameter int N  = 1024,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          vs_in,
   input logic          hs_in,
   input logic          de_in,
   input logic          vs_out,
   input logic          hs_out,
   input logic          de_out,
   input logic [CW-1:0] r_out,
   input logic [CW-1:0] g_out,
   input logic [CW-1:0] b_out
);
   int unsigned run;

   always_ff @(posedge clk) begin
      if (!rst_n || !de_out) run <= 0;
      else run <= run + 1;
   end

   p_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !de_out |-> (r_out == '0 && g_out == '0 && b_out == '0));

   p_hs_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (hs_out == $past(hs_in) && vs_out == $past(vs_in)));

   p_de_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      de_out |-> $past(de_in));

   p_max_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      de_out |-> (run < N));

   p_vs_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_in && !de_in) |=> !de_out);
endmodule

bind plane_line_reorder plane_line_reorder_chk #(.N(N), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .hs_in(hs_in), .de_in(de_in),
   .vs_out(vs_out), .hs_out(hs_out), .de_out(de_out),
   .r_out(r_out), .g_out(g_out), .b_out(b_out)
);

// File: tb/plane_line_reorder_test.sv
module plane_line_reorder_test;
   localparam int N      = 1024;
   localparam int CW     = 8;
   localparam int PERIOD = 10;
   localparam int BLANK  = 24;
   localparam int EXTRA  = 40;

   typedef struct packed {
      logic [7:0] sr, sg, sb;
      logic       vs;
      logic       lng;
   } line_t;

   localparam line_t LINES [7] = '{
      '{8'h00, 8'h55, 8'hA3, 1'b0, 1'b0},
      '{8'h11, 8'h62, 8'hC7, 1'b0, 1'b0},
      '{8'h3C, 8'h09, 8'hE1, 1'b0, 1'b0},
      '{8'h7F, 8'h20, 8'h4D, 1'b0, 1'b1},
      '{8'h90, 8'hB8, 8'h05, 1'b0, 1'b0},
      '{8'h2A, 8'hD4, 8'h6E, 1'b1, 1'b0},
      '{8'hF0, 8'h13, 8'h88, 1'b0, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, vs_in = 1'b0, hs_in = 1'b0, de_in = 1'b0;
   logic [CW-1:0] r_in = '0, g_in = '0, b_in = '0;
   logic vs_out, hs_out, de_out;
   logic [CW-1:0] r_out, g_out, b_out;

   int n_chk = 0, n_fail = 0;
   logic [7:0] prevb [3*N];
   bit exp_valid = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   plane_line_reorder #(.N(N), .CW(CW)) uut (.*);

   function automatic logic [7:0] pat(input logic [7:0] s, input int i);
      return 8'(s + i + (i >> 8) * 17);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_line(input line_t L, input int idx);
      int len = L.lng ? N + EXTRA : N;
      int de_cnt = 0, bad = 0, hs_bad = 0, dark_bad = 0, first_act = 0, first_exp = 0;
      logic prev_hs = 1'b0, prev_de = 1'b0;
      int prev_j = 0;
      if (L.vs) begin
         for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            vs_in = (v < 4);
         end
         exp_valid = 0;
      end
      for (int j = 0; j <= len + BLANK; j++) begin
         @(negedge clk);
         if (j > 0) begin
            if (hs_out !== prev_hs) hs_bad++;
            if (de_out) de_cnt++;
            if (!de_out && {r_out, g_out, b_out} != '0) dark_bad++;
            if (prev_de && prev_j < N && exp_valid) begin
               if ({r_out, g_out, b_out} !== {prevb[3*prev_j], prevb[3*prev_j+1], prevb[3*prev_j+2]}
                   || !de_out) begin
                  if (bad == 0) begin
                     first_act = int'({r_out, g_out, b_out});
                     first_exp = int'({prevb[3*prev_j], prevb[3*prev_j+1], prevb[3*prev_j+2]});
                  end
                  bad++;
               end
            end
         end
         if (j < len + BLANK) begin
            de_in = (j < len);
            hs_in = (j >= len + 4) && (j < len + 10);
            r_in  = (j < len) ? pat(L.sr, j) : '0;
            g_in  = (j < len) ? pat(L.sg, j) : '0;
            b_in  = (j < len) ? pat(L.sb, j) : '0;
            prev_hs = hs_in;
            prev_de = de_in;
            prev_j  = j;
         end
      end
      if (exp_valid) begin
         check(bad == 0, $sformatf("R2 R3 line %0d pixel data", idx), first_act, first_exp);
         check(de_cnt == N, $sformatf("R6 line %0d enable length", idx), de_cnt, N);
      end else begin
         check(de_cnt == 0, $sformatf("R4 line %0d dark after reset or vsync", idx), de_cnt, 0);
      end
      check(hs_bad == 0, $sformatf("R5 line %0d hsync delay", idx), hs_bad, 0);
      check(dark_bad == 0, $sformatf("R7 line %0d zero data when disabled", idx), dark_bad, 0);
      for (int a = 0; a < N; a++) begin
         prevb[a]       = pat(L.sr, a);
         prevb[N + a]   = pat(L.sg, a);
         prevb[2*N + a] = pat(L.sb, a);
      end
      exp_valid = 1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(de_out == 1'b0 && hs_out == 1'b0 && vs_out == 1'b0, "R1 reset sync outputs",
            int'({de_out, hs_out, vs_out}), 0);
      check({r_out, g_out, b_out} == '0, "R1 reset data outputs", int'({r_out, g_out, b_out}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(de_out == 1'b0 && {r_out, g_out, b_out} == '0, "R1 idle after reset",
            int'(de_out), 0);
      foreach (LINES[i]) run_line(LINES[i], i);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule